// File: doc/BRIEF.md
# Synthesiser Serial Control Port

This block is the two-wire serial slave that programs a frequency-synthesiser control chip. It oversamples the clock and data lines on the system clock and finds start and stop conditions. It matches a 7-bit slave address and shifts bytes in and out, acknowledging each one. Write bytes land in a shadow buffer. The 15-bit divider word moves to the active output in one step. This happens once both of its bytes have arrived, or earlier if the master ends the transfer with a STOP after only the upper part. A later control byte drives the charge-pump current, the test selection, the general purpose pin enable and the reference buffer enable.

In read mode the slave returns a status byte. The byte carries a lock flag taken from the phase detector and a power-up flag. The power-up flag is set by reset or by a brownout input and stays set until a read transaction ends with a STOP. The analog supply monitor and the phase detector are not part of this block. They appear only as the `brownout_i` and `lock_i` inputs.

Top module: `synth_ctl_port`

## Requirements
- R1: An address byte whose upper seven bits equal the ADDR parameter is acknowledged: the slave pulls data low during the ninth clock. Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R2: In a write, bits 6..0 of the first data byte give divider bits 14..8, and bit 7 of that byte is ignored. The second data byte gives divider bits 7..0. Data bytes after the third are acknowledged and have no effect.
- R3: After only the first data byte of a write, the divider output keeps its previous value.
- R4: A STOP that follows only the first data byte commits the new bits 14..8 together with the bits 7..0 already in effect.
- R5: A byte cut short by a STOP is dropped. Fields that byte would have set keep their previous values.
- R6: In the third data byte, bits 7:6 set the charge-pump current, bits 5:3 set the test selection, bit 2 sets the general purpose pin enable (1 = driven, 0 = high impedance) and bit 1 sets the reference buffer enable. Bit 0 is unused.
- R7: After reset the outputs are: divider 0, charge-pump 0, test 0, pin enable 0, reference enable 1. The power-up flag is 1.
- R8: A high brownout input returns every programmed output to its R7 default and sets the power-up flag.
- R9: The read status byte is sent MSB first. Bit 2 is the lock input, bit 1 is the power-up flag and all other bits are 0. The byte repeats for as long as the master acknowledges.
- R10: The power-up flag clears only when a read transaction ends with a STOP. A write ended by a STOP leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 = slave pulls the data line low |
| brownout_i | input | 1 | Supply brownout indication |
| lock_i | input | 1 | Synthesiser lock indication |
| freq_o | output | 15 | Active divider word |
| cp_cur_o | output | 2 | Charge-pump current select |
| test_sel_o | output | 3 | Test mode select |
| gp_en_o | output | 1 | General purpose pin drive enable |
| ref_en_o | output | 1 | Reference buffer enable |

## Verification
The hardest cases to reach are those where a STOP arrives at the wrong moment. One is a STOP after exactly one divider byte. Another is a STOP in the middle of the bits of a later byte. The bench's bus master can leave a byte after any number of bits and issue STOP from a low clock. It then compares the divider and control outputs against the halves it knows were committed before. The power-up flag is driven by a brownout pulse and is then checked across a write that ends in STOP and across a read that ends in STOP.

// File: rtl/synth_ctl_pkg.sv
// Shared constants and types for the synthesiser serial control port.
package synth_ctl_pkg;

    localparam int BYTE_W   = 8;
    localparam int FREQ_W   = 15;
    localparam int FHI_W    = FREQ_W - BYTE_W;   // upper divider bits
    localparam int CP_W     = 2;
    localparam int TEST_W   = 3;
    localparam int IDX_W    = 2;                 // data byte index width

    // Control byte field positions
    localparam int CP_LSB   = 6;
    localparam int TEST_LSB = 3;
    localparam int GP_BIT   = 2;
    localparam int REF_BIT  = 1;

    // Status byte bit positions
    localparam int ST_POR   = 1;
    localparam int ST_LOCK  = 2;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_ACK_A,
        LS_WDATA,
        LS_ACK_W,
        LS_RDATA,
        LS_ACK_R
    } link_state_e;

endpackage

// File: rtl/line_watch.sv
// Line watcher: synchronises the serial clock and data lines into the
// system clock domain and reports start, stop and clock edge events.
// Assumes both lines are much slower than clk (several clocks per phase).
module line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic sda_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchroniser chains, idle-high at reset
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sync[g] <= 1'b1;
                    sda_sync[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_sync[g] <= scl_i;
                    sda_sync[g] <= sda_i;
                end else begin
                    scl_sync[g] <= scl_sync[(g > 0) ? g-1 : 0];
                    sda_sync[g] <= sda_sync[(g > 0) ? g-1 : 0];
                end
            end
        end
    endgenerate

    // Previous-sample registers for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_sync[LAST];
            sda_prev <= sda_sync[LAST];
        end
    end

    // Event decode from current and previous samples
    always_comb begin
        sda_s     = sda_sync[LAST];
        scl_rise  = scl_sync[LAST] & ~scl_prev;
        scl_fall  = ~scl_sync[LAST] & scl_prev;
        start_evt = scl_sync[LAST] & scl_prev & sda_prev & ~sda_sync[LAST];
        stop_evt  = scl_sync[LAST] & scl_prev & ~sda_prev & sda_sync[LAST];
    end

endmodule

// File: rtl/link_engine.sv
// Byte engine: address match, bit shifting, acknowledge and status
// transmission. Emits a strobe per completed write byte and reports the
// end of each transaction. Partial bytes never produce a strobe.
module link_engine
    import synth_ctl_pkg::*;
#(
    parameter logic [6:0] ADDR = 7'h61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              end_stb,
    output logic              end_read
);
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    link_state_e       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              read_txn;
    logic              mack;
    logic              byte_full;

    assign byte_full = (bit_cnt == CNT_W'(BYTE_W));

    // Transaction end report, with whether it was an addressed read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_stb  <= 1'b0;
            end_read <= 1'b0;
        end else begin
            end_stb  <= stop_evt;
            end_read <= stop_evt & read_txn;
        end
    end

    // Main protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LS_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            idx      <= '0;
            read_txn <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_evt) begin
                state    <= LS_ADDR;
                bit_cnt  <= '0;
                idx      <= '0;
                read_txn <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop_evt) begin
                state    <= LS_IDLE;
                read_txn <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    LS_ADDR, LS_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && byte_full) begin
                            if (state == LS_ADDR) begin
                                if (shreg[BYTE_W-1:1] == ADDR) begin
                                    state    <= LS_ACK_A;
                                    sda_pull <= 1'b1;
                                    read_txn <= shreg[0];
                                end else begin
                                    state <= LS_IDLE;
                                end
                            end else begin
                                wr_stb   <= 1'b1;
                                wr_idx   <= idx;
                                wr_data  <= shreg;
                                state    <= LS_ACK_W;
                                sda_pull <= 1'b1;
                            end
                        end
                    end
                    LS_ACK_A: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (read_txn) begin
                                state    <= LS_RDATA;
                                shreg    <= status_i;
                                sda_pull <= ~status_i[BYTE_W-1];
                            end else begin
                                state    <= LS_WDATA;
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    LS_ACK_W: begin
                        if (scl_fall) begin
                            state    <= LS_WDATA;
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            if (idx != IDX_MAX) idx <= idx + 1'b1;
                        end
                    end
                    LS_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                                state    <= LS_ACK_R;
                                sda_pull <= 1'b0;
                            end else begin
                                bit_cnt  <= bit_cnt + 1'b1;
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    LS_ACK_R: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (mack) begin
                                state    <= LS_RDATA;
                                shreg    <= status_i;
                                sda_pull <= ~status_i[BYTE_W-1];
                            end else begin
                                state <= LS_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_pull);

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/ctl_regs.sv
// Control register file: shadow buffer for the upper divider bits, atomic
// commit of the divider word, control field decode and the power-up flag.
// Assumes write strobes carry the data byte index since the address byte.
module ctl_regs
    import synth_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              end_stb,
    input  logic              end_read,
    input  logic              brownout,
    input  logic              lock,
    output logic [FREQ_W-1:0] freq_q,
    output logic [CP_W-1:0]   cp_q,
    output logic [TEST_W-1:0] test_q,
    output logic              gp_q,
    output logic              ref_q,
    output logic [BYTE_W-1:0] status_o
);
    logic [FHI_W-1:0] shadow_hi;
    logic             pend_hi;
    logic             por_q;

    // Divider shadow and commit
    always_ff @(posedge clk) begin
        if (!rst_n || brownout) begin
            freq_q    <= '0;
            shadow_hi <= '0;
            pend_hi   <= 1'b0;
        end else if (wr_stb && wr_idx == IDX_W'(0)) begin
            shadow_hi <= wr_data[FHI_W-1:0];
            pend_hi   <= 1'b1;
        end else if (wr_stb && wr_idx == IDX_W'(1)) begin
            freq_q  <= {shadow_hi, wr_data};
            pend_hi <= 1'b0;
        end else if (end_stb && pend_hi) begin
            freq_q  <= {shadow_hi, freq_q[BYTE_W-1:0]};
            pend_hi <= 1'b0;
        end
    end

    // Control fields from the third data byte
    always_ff @(posedge clk) begin
        if (!rst_n || brownout) begin
            cp_q   <= '0;
            test_q <= '0;
            gp_q   <= 1'b0;
            ref_q  <= 1'b1;
        end else if (wr_stb && wr_idx == IDX_W'(2)) begin
            cp_q   <= wr_data[CP_LSB +: CP_W];
            test_q <= wr_data[TEST_LSB +: TEST_W];
            gp_q   <= wr_data[GP_BIT];
            ref_q  <= wr_data[REF_BIT];
        end
    end

    // Power-up flag: set by reset or brownout, cleared by read end
    always_ff @(posedge clk) begin
        if (!rst_n || brownout) por_q <= 1'b1;
        else if (end_read)      por_q <= 1'b0;
    end

    // Status byte assembly
    always_comb begin
        status_o          = '0;
        status_o[ST_POR]  = por_q;
        status_o[ST_LOCK] = lock;
    end

    // R3
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !end_stb && !brownout) |=> $stable(freq_q));

    // R8
    brownout_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brownout |=> (ref_q && por_q && freq_q == '0 && cp_q == '0));

    // R10
    por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_q) |-> $past(end_read));

endmodule

// File: rtl/synth_ctl_port.sv
// Top level of the synthesiser serial control port: line watcher, byte
// engine and control registers. Assumes an external pull-up on the data
// line; the slave only pulls it low through sda_pull_o.
module synth_ctl_port
    import synth_ctl_pkg::*;
#(
    parameter logic [6:0] ADDR        = 7'h61,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              brownout_i,
    input  logic              lock_i,
    output logic [FREQ_W-1:0] freq_o,
    output logic [CP_W-1:0]   cp_cur_o,
    output logic [TEST_W-1:0] test_sel_o,
    output logic              gp_en_o,
    output logic              ref_en_o
);
    logic              scl_rise, scl_fall, start_evt, stop_evt, sda_s;
    logic              wr_stb, end_stb, end_read;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] status;

    line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s)
    );

    link_engine #(.ADDR(ADDR)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s),
        .status_i  (status),
        .sda_pull  (sda_pull_o),
        .wr_stb    (wr_stb),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .end_stb   (end_stb),
        .end_read  (end_read)
    );

    ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .end_stb  (end_stb),
        .end_read (end_read),
        .brownout (brownout_i),
        .lock     (lock_i),
        .freq_q   (freq_o),
        .cp_q     (cp_cur_o),
        .test_q   (test_sel_o),
        .gp_q     (gp_en_o),
        .ref_q    (ref_en_o),
        .status_o (status)
    );

    // R9
    status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:3] == '0) && (status[0] == 1'b0));

endmodule

// File: tb/synth_ctl_port_test.sv
// Scoreboard bench: bus tasks push expected items, a monitor pops and
// compares them against outputs or values captured on the bus.
module synth_ctl_port_test;

    localparam logic [6:0] ADDR = 7'h61;
    localparam int Q = 8;

    localparam int K_FREQ = 0, K_CP = 1, K_TEST = 2, K_GP = 3, K_REF = 4, K_CAP = 5;

    typedef struct {
        string tag;
        int    kind;
        int    exp;
        int    cap;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_drv = 1'b1;
    logic        sda_drv = 1'b1;
    logic        brownout = 1'b0;
    logic        lock = 1'b0;
    logic        sda_pull;
    logic        sda_line;
    logic [14:0] freq;
    logic [1:0]  cp;
    logic [2:0]  tsel;
    logic        gp_en, ref_en;

    int     total = 0;
    int     bad = 0;
    item_t  sb[$];
    logic   done = 1'b0;

    assign sda_line = sda_drv & ~sda_pull;

    always #2 clk = ~clk;

    synth_ctl_port #(.ADDR(ADDR)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .brownout_i (brownout),
        .lock_i     (lock),
        .freq_o     (freq),
        .cp_cur_o   (cp),
        .test_sel_o (tsel),
        .gp_en_o    (gp_en),
        .ref_en_o   (ref_en)
    );

    // Monitor: pop one expected item per falling edge and compare
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            int act;
            it = sb.pop_front();
            case (it.kind)
                K_FREQ:  act = int'(freq);
                K_CP:    act = int'(cp);
                K_TEST:  act = int'(tsel);
                K_GP:    act = int'(gp_en);
                K_REF:   act = int'(ref_en);
                default: act = it.cap;
            endcase
            total++;
            if (act != it.exp) begin
                bad++;
                $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input string tag, input int kind, input int exp, input int cap);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp; it.cap = cap;
        sb.push_back(it);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_drv = b; wq(Q);
        scl_drv = 1'b1; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q/2);
        ack = ~sda_line; wq(Q/2);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = 1'b1; wq(Q);
            scl_drv = 1'b1; wq(Q/2);
            d[i] = sda_line; wq(Q/2);
            scl_drv = 1'b0; wq(Q);
        end
        put_bit(~master_ack);
        sda_drv = 1'b1;
    endtask

    task automatic check_ctl(input string tag, input int c, input int t, input int g, input int r);
        push({tag, " cp"}, K_CP, c, 0);
        push({tag, " test"}, K_TEST, t, 0);
        push({tag, " gp"}, K_GP, g, 0);
        push({tag, " ref"}, K_REF, r, 0);
        drain();
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        wq(150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R7 reset defaults
        push("R7 freq", K_FREQ, 0, 0);
        check_ctl("R7", 0, 0, 0, 1);

        // R9 status with flag set and lock high, repeated, R7 flag after reset
        lock = 1'b1;
        bus_start();
        put_byte({ADDR, 1'b1}, ack);
        push("R1 read addr ack", K_CAP, 1, int'(ack));
        get_byte(1'b1, rd);
        push("R9 R7 status first", K_CAP, 8'h06, int'(rd));
        get_byte(1'b0, rd);
        push("R9 status repeat", K_CAP, 8'h06, int'(rd));
        bus_stop();
        drain();

        // R10 flag cleared by read ended with STOP
        bus_start();
        put_byte({ADDR, 1'b1}, ack);
        get_byte(1'b0, rd);
        push("R10 flag cleared after read", K_CAP, 8'h04, int'(rd));
        bus_stop();
        drain();

        // R1 wrong address: no ack, writes ignored
        bus_start();
        put_byte({ADDR ^ 7'h01, 1'b0}, ack);
        push("R1 mismatch no ack", K_CAP, 0, int'(ack));
        put_byte(8'h12, ack);
        put_byte(8'h34, ack);
        bus_stop();
        push("R1 ignored write freq", K_FREQ, 0, 0);
        drain();

        // R2 R3 R6 full write with extra byte
        bus_start();
        put_byte({ADDR, 1'b0}, ack);
        push("R1 write addr ack", K_CAP, 1, int'(ack));
        put_byte(8'h95, ack);
        push("R3 freq held mid frame", K_FREQ, 0, 0);
        drain();
        put_byte(8'hA3, ack);
        push("R2 freq after two bytes", K_FREQ, 15'h15A3, 0);
        drain();
        put_byte(8'hAC, ack);
        check_ctl("R6", 2, 5, 1, 0);
        put_byte(8'hFF, ack);
        push("R2 extra byte acked", K_CAP, 1, int'(ack));
        bus_stop();
        check_ctl("R2 extra byte ignored", 2, 5, 1, 0);

        // R4 STOP after first byte commits upper bits
        bus_start();
        put_byte({ADDR, 1'b0}, ack);
        put_byte(8'h2B, ack);
        bus_stop();
        push("R4 stop commit", K_FREQ, 15'h2BA3, 0);
        drain();

        // R5 partial second byte dropped
        bus_start();
        put_byte({ADDR, 1'b0}, ack);
        put_byte(8'h11, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        push("R5 partial low byte", K_FREQ, 15'h11A3, 0);
        drain();

        // R5 partial control byte dropped
        bus_start();
        put_byte({ADDR, 1'b0}, ack);
        put_byte(8'h01, ack);
        put_byte(8'h02, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
        bus_stop();
        push("R5 freq before partial", K_FREQ, 15'h0102, 0);
        check_ctl("R5 partial ctl", 2, 5, 1, 0);

        // R8 brownout restores defaults
        brownout = 1'b1; wq(2);
        brownout = 1'b0; wq(2);
        push("R8 freq", K_FREQ, 0, 0);
        check_ctl("R8", 0, 0, 0, 1);

        // R10 write with STOP leaves flag set; R8 flag set by brownout
        bus_start();
        put_byte({ADDR, 1'b0}, ack);
        put_byte(8'h05, ack);
        put_byte(8'h06, ack);
        bus_stop();
        lock = 1'b0;
        bus_start();
        put_byte({ADDR, 1'b1}, ack);
        get_byte(1'b0, rd);
        push("R10 R8 flag kept after write", K_CAP, 8'h02, int'(rd));
        bus_stop();
        push("R2 freq second write", K_FREQ, 15'h0506, 0);
        drain();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule